// File: doc/BRIEF.md
# MDIO Serial Management Master

This block is the master of the two-wire station management link between a MAC-side host and an external PHY. It divides the system clock down to the management clock `mdc` with an 8-bit programmable divider. On the bidirectional data line it runs single register writes, single register reads, and a continuous scan that keeps polling one PHY register until it is told to stop. The data line is presented as a split output / output-enable / input triple. The pad and its pull-up sit outside the block.

The host drives the PHY address, the register address, the write data, the divider value and a flag that suppresses the 32-bit all-ones preamble. It starts a transaction with a one-cycle strobe: write, read, scan or stop-scan. The block reports `busy` while a transaction is in progress. It also reports `notValid` until the first word of a scan has been captured, the most recent read word, and a link-fail flag taken from the scanned status word.

Top module: `mdioMaster`

## Requirements
- R1: The `mdc` high and low phases each last max(cfgDivider, 2) system clock cycles, for every divider value from 0 to 255.
- R2: A write frame on the line consists of the following, in order:
  - the 32-bit all-ones preamble, unless it is suppressed;
  - start bits 0,1;
  - opcode 0,1;
  - the 5 PHY address bits, MSB first;
  - the 5 register address bits, MSB first;
  - turnaround bits 1,0;
  - the 16 data bits, MSB first.

  The data output changes only in a cycle in which `mdc` falls.
- R3: A read frame uses opcode 1,0 and releases the output enable from the first turnaround bit to the end of the frame. It samples the 16 data bits on rising `mdc`, MSB first. `readData` holds the word when `busy` falls.
- R4: With `cfgNoPreamble` = 1, reads and writes work without the preamble. A frame then spans 32 fewer `mdc` periods: about 32 rising edges of `mdc` while busy, instead of about 64.
- R5: A read from a PHY address that no device answers returns 16'hFFFF, because the line floats high.
- R6: `busy` rises the cycle after an accepted command and stays high until the last frame ends. A command strobe that arrives while `busy` is high is ignored.
- R7: A scan repeats read frames to the selected register and updates `readData` after each frame. `linkFail` is the inverse of bit 2 (the link-status bit) of the latest scanned word.
- R8: `notValid` is high from the start of a scan until its first word has been captured. It stays low for single reads and writes.
- R9: A stop-scan strobe lets the frame in progress complete, after which the block goes idle. This holds when stop-scan arrives during a scan, during a read or write, or in the same cycle as the scan strobe (then exactly one frame is run). Stop-scan while idle has no effect.
- R10: When several command strobes arrive in the same idle cycle, write wins over read, and read wins over scan.
- R11: After reset, `busy`, `notValid`, `mdioOe`, `linkFail` and `readData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDivider | input | 8 | Management clock half-period in system cycles (minimum 2) |
| cfgNoPreamble | input | 1 | 1 = omit the 32-bit preamble |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| writeData | input | 16 | Data for a write frame |
| cmdWrite | input | 1 | Start a write (one-cycle strobe) |
| cmdRead | input | 1 | Start a read (one-cycle strobe) |
| cmdScan | input | 1 | Start a continuous scan (one-cycle strobe) |
| cmdStopScan | input | 1 | End the scan after the current frame |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line input (pulled up externally) |
| busy | output | 1 | Transaction in progress |
| notValid | output | 1 | Scan has not yet captured a word |
| readData | output | 16 | Latest read or scanned word |
| linkFail | output | 1 | Inverse of the link-status bit of the latest scanned word |

## Verification
The bench builds the block with its default parameters: 8-bit divider, 5-bit addresses, 16-bit data, 32-bit preamble and link bit 2. With these, every frame matches the standard management layout that a behavioural PHY in the bench decodes bit by bit. The divider is swept over its clamp region (0, 1, 2, 3), a few random values and the maximum 255. Most traffic runs at the fastest legal divider, so random writes, reads, scans and stop-scan races all fit in a short run, both with and without the preamble.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_READ  = 2'd1,
    MODE_SCAN  = 2'd2
  } xferMode_t;

  // strobes passed from the sequencer to the shift datapath
  typedef struct packed {
    logic load;       // latch fields and build a new frame
    logic loadWrite;  // the frame being loaded is a write
    logic drive;      // present the next frame bit
    logic sample;     // shift in the line value
    logic finish;     // frame ends on this edge
    logic restart;    // scan continues with another frame
    logic readFrame;  // current frame is a read or scan
    logic scanFrame;  // current frame belongs to a scan
  } ctlStrobes_t;

endpackage

// File: rtl/mdioClkGen.sv
module mdioClkGen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divider,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic             wrap;

  assign half     = (divider < MIN_HALF) ? MIN_HALF : divider;
  assign wrap     = (cnt >= half - DIV_W'(1));
  assign riseTick = wrap && !mdc;
  assign fallTick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R1: no phase shorter than two system cycles
  a_r1_min_half: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdc) |=> $stable(mdc));

endmodule

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdio_pkg::*;
#(
  parameter int FRAME_LEN  = 64,
  parameter int PRE_LEN    = 32,
  parameter int DATA_START = 48,
  parameter int POS_W      = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic        cmdRead,
  input  logic        cmdScan,
  input  logic        cmdStopScan,
  input  logic        noPreamble,
  input  logic        riseTick,
  input  logic        fallTick,
  output logic        busy,
  output logic        notValid,
  output ctlStrobes_t strobes
);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN);
  localparam logic [POS_W-1:0] DATA_POS  = POS_W'(DATA_START);
  localparam logic [POS_W-1:0] PRE_POS   = POS_W'(PRE_LEN);

  xferMode_t        mode;
  logic             active;
  logic             stopReq;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] posStart;
  logic             accept;
  logic             readFrame;
  logic             scanFrame;
  logic             drive;
  logic             finish;
  logic             restart;
  logic             sample;

  assign accept    = !active && (cmdWrite || cmdRead || cmdScan);
  assign readFrame = (mode != MODE_WRITE);
  assign scanFrame = (mode == MODE_SCAN);
  assign drive     = active && fallTick && (pos < LAST_POS);
  assign finish    = active && fallTick && (pos == LAST_POS);
  assign restart   = finish && scanFrame && !stopReq && !cmdStopScan;
  assign sample    = active && riseTick && readFrame &&
                     (pos > DATA_POS) && (pos <= LAST_POS);

  always_comb begin
    strobes.load      = accept;
    strobes.loadWrite = cmdWrite;
    strobes.drive     = drive;
    strobes.sample    = sample;
    strobes.finish    = finish;
    strobes.restart   = restart;
    strobes.readFrame = readFrame;
    strobes.scanFrame = scanFrame;
  end

  assign busy = active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      mode     <= MODE_WRITE;
      stopReq  <= 1'b0;
      pos      <= '0;
      posStart <= '0;
      notValid <= 1'b0;
    end else if (accept) begin
      // R10: write over read over scan
      active   <= 1'b1;
      mode     <= cmdWrite ? MODE_WRITE : (cmdRead ? MODE_READ : MODE_SCAN);
      stopReq  <= cmdStopScan;
      pos      <= noPreamble ? PRE_POS : '0;
      posStart <= noPreamble ? PRE_POS : '0;
      notValid <= !cmdWrite && !cmdRead;
    end else if (active) begin
      if (cmdStopScan) stopReq <= 1'b1;
      if (drive) pos <= pos + POS_W'(1);
      if (finish) begin
        if (scanFrame) notValid <= 1'b0;
        if (restart) begin
          pos <= posStart;
        end else begin
          active  <= 1'b0;
          stopReq <= 1'b0;
        end
      end
    end
  end

  // R8: not-valid only while a transaction is running
  a_r8_nv_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    notValid |-> busy);

  // R9: a finished frame with a pending stop leaves the block idle
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (finish && stopReq) |=> !busy);

endmodule

// File: rtl/mdioShift.sv
module mdioShift
  import mdio_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int FRAME_LEN = 64,
  parameter int TA_START  = 46,
  parameter int POS_W     = 7,
  parameter int LINK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [POS_W-1:0]  curPos,
  input  logic              noPreamble,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] writeData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [DATA_W-1:0] readData,
  output logic              linkFail
);
  localparam int BODY_LEN = FRAME_LEN - PRE_LEN;
  localparam logic [POS_W-1:0] TA_POS = POS_W'(TA_START);

  logic [FRAME_LEN-1:0] frame;
  logic [FRAME_LEN-1:0] tmpl;
  logic [FRAME_LEN-1:0] newFrame;
  logic [BODY_LEN-1:0]  body;
  logic [DATA_W-1:0]    shiftIn;

  // R2 R3: start, opcode, addresses, turnaround, data
  assign body = strobes.loadWrite ?
                {2'b01, 2'b01, phyAddr, regAddr, 2'b10, writeData} :
                {2'b01, 2'b10, phyAddr, regAddr, 2'b11, {DATA_W{1'b1}}};
  assign newFrame = noPreamble ? {body, {PRE_LEN{1'b1}}} :
                                 {{PRE_LEN{1'b1}}, body};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame    <= '1;
      tmpl     <= '1;
      shiftIn  <= '0;
      mdioOut  <= 1'b1;
      mdioOe   <= 1'b0;
      readData <= '0;
      linkFail <= 1'b0;
    end else begin
      if (strobes.load) begin
        frame <= newFrame;
        tmpl  <= newFrame;
      end
      if (strobes.drive) begin
        mdioOut <= frame[FRAME_LEN-1];
        mdioOe  <= !strobes.readFrame || (curPos < TA_POS);
        frame   <= {frame[FRAME_LEN-2:0], 1'b1};
      end
      if (strobes.sample) shiftIn <= {shiftIn[DATA_W-2:0], mdioIn};
      if (strobes.finish) begin
        mdioOe <= 1'b0;
        if (strobes.readFrame) readData <= shiftIn;
        if (strobes.scanFrame) linkFail <= ~shiftIn[LINK_BIT];
        if (strobes.restart) frame <= tmpl;
      end
    end
  end

  // R3: the line is never driven while read data is taken in
  a_r3_released: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample |-> !mdioOe);

endmodule

// File: rtl/mdioMaster.sv
module mdioMaster
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_LEN  = 32,
  parameter int LINK_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgDivider,
  input  logic              cfgNoPreamble,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] writeData,
  input  logic              cmdWrite,
  input  logic              cmdRead,
  input  logic              cmdScan,
  input  logic              cmdStopScan,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn,
  output logic              busy,
  output logic              notValid,
  output logic [DATA_W-1:0] readData,
  output logic              linkFail
);
  localparam int FRAME_LEN  = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int DATA_START = FRAME_LEN - DATA_W;
  localparam int TA_START   = DATA_START - 2;
  localparam int POS_W      = $clog2(FRAME_LEN + 1);

  logic        riseTick;
  logic        fallTick;
  ctlStrobes_t strobes;
  logic [POS_W-1:0] curPos;

  mdioClkGen #(.DIV_W(DIV_W)) uClk (
    .clk(clk), .rstN(rstN), .divider(cfgDivider),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  mdioCtrl #(
    .FRAME_LEN(FRAME_LEN), .PRE_LEN(PRE_LEN),
    .DATA_START(DATA_START), .POS_W(POS_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdWrite(cmdWrite), .cmdRead(cmdRead), .cmdScan(cmdScan),
    .cmdStopScan(cmdStopScan), .noPreamble(cfgNoPreamble),
    .riseTick(riseTick), .fallTick(fallTick),
    .busy(busy), .notValid(notValid), .strobes(strobes)
  );

  assign curPos = uCtrl.pos;

  mdioShift #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN),
    .FRAME_LEN(FRAME_LEN), .TA_START(TA_START), .POS_W(POS_W),
    .LINK_BIT(LINK_BIT)
  ) uShift (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curPos(curPos),
    .noPreamble(cfgNoPreamble), .phyAddr(phyAddr), .regAddr(regAddr),
    .writeData(writeData), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe),
    .readData(readData), .linkFail(linkFail)
  );

  // R2: output data moves only with a falling management clock
  a_r2_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> $fell(mdc));

  // R6: the line is driven only inside a transaction
  a_r6_oe_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);

endmodule

// File: tb/sim_mdioMaster.sv
module sim_mdioMaster;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgDivider = 8'd2;
  logic        cfgNoPreamble = 1'b0;
  logic [4:0]  phyAddr = 5'd3;
  logic [4:0]  regAddr = 5'd0;
  logic [15:0] writeData = 16'h0;
  logic        cmdWrite = 1'b0, cmdRead = 1'b0, cmdScan = 1'b0, cmdStopScan = 1'b0;
  logic        mdc, mdioOut, mdioOe, mdioIn, busy, notValid, linkFail;
  logic [15:0] readData;

  logic        phyEn = 1'b0, phyBit = 1'b1;
  logic [15:0] phyRegs [32];
  logic [1:0]  lastTa = 2'b00;
  int          phyReads = 0, phyWrites = 0;
  int          mdcInBusy = 0;
  int          checks = 0, errors = 0;
  localparam logic [4:0] PHY_ADR = 5'd3;

  assign mdioIn = mdioOe ? mdioOut : (phyEn ? phyBit : 1'b1);

  always #4 clk = ~clk;

  mdioMaster u0 (
    .clk(clk), .rstN(rstN), .cfgDivider(cfgDivider), .cfgNoPreamble(cfgNoPreamble),
    .phyAddr(phyAddr), .regAddr(regAddr), .writeData(writeData),
    .cmdWrite(cmdWrite), .cmdRead(cmdRead), .cmdScan(cmdScan), .cmdStopScan(cmdStopScan),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn),
    .busy(busy), .notValid(notValid), .readData(readData), .linkFail(linkFail)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural PHY: decodes frames on rising mdc, answers on falling mdc
  task automatic getBit(output logic b);
    @(posedge mdc);
    #1 b = mdioIn;
  endtask

  initial begin
    logic b, b1;
    logic [1:0] op;
    logic [4:0] pa, ra;
    logic [15:0] val;
    for (int i = 0; i < 32; i++) phyRegs[i] = 16'(i * 16'h1111);
    forever begin
      getBit(b);
      if (b == 1'b0) begin
        getBit(b);
        if (b == 1'b1) begin
          getBit(op[1]); getBit(op[0]);
          for (int i = 4; i >= 0; i--) getBit(pa[i]);
          for (int i = 4; i >= 0; i--) getBit(ra[i]);
          if (op == 2'b10) begin
            if (pa == PHY_ADR) begin
              @(negedge mdc);
              @(negedge mdc); #1 phyEn = 1'b1; phyBit = 1'b0;
              val = phyRegs[ra];
              for (int i = 15; i >= 0; i--) begin
                @(negedge mdc); #1 phyBit = val[i];
              end
              @(negedge mdc); #1 phyEn = 1'b0;
              phyReads++;
            end else begin
              repeat (18) getBit(b1);
            end
          end else if (op == 2'b01) begin
            getBit(lastTa[1]); getBit(lastTa[0]);
            for (int i = 15; i >= 0; i--) getBit(val[i]);
            if (pa == PHY_ADR) phyRegs[ra] = val;
            phyWrites++;
          end
        end
      end
    end
  end

  initial forever begin
    @(posedge mdc);
    #1 if (busy) mdcInBusy++;
  end

  task automatic pulse(input int kind);
    @(negedge clk);
    case (kind)
      0: cmdWrite = 1'b1;
      1: cmdRead = 1'b1;
      2: cmdScan = 1'b1;
      default: cmdStopScan = 1'b1;
    endcase
    @(negedge clk);
    cmdWrite = 1'b0; cmdRead = 1'b0; cmdScan = 1'b0; cmdStopScan = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int halfOf(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic doWrite(input logic [4:0] ra, input logic [15:0] d);
    regAddr = ra; writeData = d;
    pulse(0); waitIdle();
  endtask

  task automatic doRead(input logic [4:0] ra);
    regAddr = ra;
    pulse(1); waitIdle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, d, wc, rc;
    logic [4:0] ra;
    logic [15:0] dat;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!busy && !notValid && !mdioOe && !linkFail && readData == 16'h0,
          "R11 reset state", {busy, notValid, mdioOe, linkFail}, 0);

    // R1 divider sweep including clamp region
    foreach (d_list[i]) begin
      cfgDivider = 8'(d_list[i]);
      repeat (3) @(posedge mdc);
      n = 0;
      do begin
        @(posedge clk); #1 n++;
      end while (mdc);
      check(n == halfOf(d_list[i]), "R1 mdc half period", n, halfOf(d_list[i]));
    end
    cfgDivider = 8'd2;
    repeat (4) @(posedge mdc);
    @(negedge clk);

    // R2 R3 R4 random writes and read-backs with and without preamble
    for (int t = 0; t < 8; t++) begin
      ra = 5'($urandom_range(2, 31));
      dat = 16'($urandom);
      cfgNoPreamble = t[0];
      mdcInBusy = 0;
      doWrite(ra, dat);
      check(t[0] ? (mdcInBusy == 32 || mdcInBusy == 33) : (mdcInBusy == 64 || mdcInBusy == 65),
            "R4 frame length", mdcInBusy, t[0] ? 32 : 64);
      check(phyRegs[ra] == dat, "R2 write reached PHY", phyRegs[ra], dat);
      check(lastTa == 2'b10, "R2 write turnaround", lastTa, 2);
      doRead(ra);
      check(readData == dat, "R3 read back", readData, dat);
    end
    cfgNoPreamble = 1'b0;

    // R5 wrong address reads all ones, wrong-address write leaves PHY alone
    phyAddr = 5'd2;
    doRead(5'd4);
    check(readData == 16'hFFFF, "R5 no responder", readData, 16'hFFFF);
    dat = phyRegs[6];
    doWrite(5'd6, ~dat);
    phyAddr = PHY_ADR;
    doRead(5'd6);
    check(readData == dat, "R5 wrong-address write ignored", readData, dat);

    // R6 busy timing and command ignored while busy
    phyRegs[5] = 16'hA5C3;
    regAddr = 5'd5;
    pulse(1);
    check(busy, "R6 busy after command", busy, 1);
    check(!notValid, "R8 low for single read", notValid, 0);
    wc = phyWrites;
    writeData = 16'h1234;
    pulse(0);
    waitIdle();
    check(readData == 16'hA5C3 && phyWrites == wc && phyRegs[5] == 16'hA5C3,
          "R6 command while busy ignored", phyRegs[5], 16'hA5C3);

    // R10 simultaneous write and read: write wins
    regAddr = 5'd7; writeData = 16'h0F0F;
    wc = phyWrites; rc = phyReads;
    @(negedge clk); cmdWrite = 1'b1; cmdRead = 1'b1;
    @(negedge clk); cmdWrite = 1'b0; cmdRead = 1'b0;
    waitIdle();
    check(phyWrites == wc + 1 && phyReads == rc && phyRegs[7] == 16'h0F0F,
          "R10 write over read", phyRegs[7], 16'h0F0F);
    // read over scan
    rc = phyReads;
    @(negedge clk); cmdRead = 1'b1; cmdScan = 1'b1;
    @(negedge clk); cmdRead = 1'b0; cmdScan = 1'b0;
    waitIdle();
    check(phyReads == rc + 1 && !busy, "R10 read over scan", phyReads - rc, 1);

    // R7 R8 R9 scan of status register
    for (int p = 0; p < 2; p++) begin
      cfgNoPreamble = p[0];
      phyRegs[1] = 16'h786D;
      regAddr = 5'd1;
      pulse(2);
      check(notValid && busy, "R8 not-valid at scan start", notValid, 1);
      while (notValid) @(negedge clk);
      check(readData == 16'h786D && !linkFail && busy, "R7 first scan word", readData, 16'h786D);
      phyRegs[1] = 16'h7869;
      rc = phyReads;
      while (phyReads < rc + 2) @(negedge clk);
      repeat (2) @(negedge clk);
      check(linkFail && readData == 16'h7869, "R7 link fail seen", linkFail, 1);
      pulse(3);
      waitIdle();
      rc = phyReads;
      repeat (400) @(negedge clk);
      check(!busy && phyReads == rc && !mdioOe, "R9 scan stopped", phyReads - rc, 0);
    end
    cfgNoPreamble = 1'b0;

    // R9 stop right after a read request
    phyRegs[9] = 16'hBEEF;
    regAddr = 5'd9;
    pulse(1); pulse(3);
    waitIdle();
    check(readData == 16'hBEEF && !busy, "R9 read completes despite stop", readData, 16'hBEEF);

    // R9 stop in the same cycle as scan: exactly one frame
    rc = phyReads;
    regAddr = 5'd1;
    @(negedge clk); cmdScan = 1'b1; cmdStopScan = 1'b1;
    @(negedge clk); cmdScan = 1'b0; cmdStopScan = 1'b0;
    waitIdle();
    repeat (300) @(negedge clk);
    check(phyReads == rc + 1 && !notValid && !busy, "R9 one scan frame", phyReads - rc, 1);

    // R9 stop while idle has no effect
    pulse(3);
    repeat (20) @(negedge clk);
    check(!busy && !mdioOe, "R9 idle stop ignored", busy, 0);
    // a following scan still runs more than one frame
    rc = phyReads;
    pulse(2);
    while (phyReads < rc + 2) @(negedge clk);
    check(busy, "R9 scan after idle stop continues", busy, 1);
    pulse(3);
    waitIdle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int d_list [8] = '{0, 1, 2, 3, 7, 19, 100, 255};

endmodule